// File: doc/BRIEF.md
# SDRAM Read Burst Scheduler

This block runs the read side of a single-data-rate SDRAM controller. Read requests carry a bank, a column and a tag. They arrive over a valid/ready handshake. Each accepted request becomes one READ command on the SDRAM command bus. On every other cycle the bus carries NOP. All rows are taken to be open already, so no activation or precharge is issued.

Each READ returns a burst of four words, one per clock, after a programmable CAS latency of 1, 2 or 3 cycles. The block captures each word from the data input after that latency. It presents each word with a valid flag, the request tag, the word's index inside the burst and a last-of-burst flag.

Requests are accepted on a fixed cadence, so the captured stream has no idle cycle between bursts. The cadence does not depend on the latency or on which banks are used. If the device is programmed with a longer burst, the next READ cuts the earlier burst short. Any words after the fourth are never presented.

Top module: `sdr_rd_sched`

## Requirements
- R1: While reset is asserted, sd_cmd is NOP (3'b111, the ras_n/cas_n/we_n levels), sd_dqm is 1, rsp_valid is 0 and req_ready is 1.
- R2: A handshake (req_valid and req_ready high at a rising edge) puts READ (3'b101) on sd_cmd for exactly the one cycle after that edge. In that cycle sd_ba and sd_addr carry the request's bank and column. Every cycle without a READ carries NOP.
- R3: After a handshake, req_ready stays low for the next BURST_LEN-1 cycles and is high in the cycle after those. READ commands are therefore at least BURST_LEN cycles apart, and exactly BURST_LEN apart when requests wait. This holds for the same bank and for different banks.
- R4: Let E be the rising edge that ends a READ cycle. Word k (0..3) of that READ is sampled from sd_dq_in at the edge CL+k edges after E. It appears on rsp_data with rsp_valid high in the cycle after that sampling edge.
- R5: The latency CL follows cfg_cas_lat for the values 1, 2 and 3. The value 0 behaves as 1.
- R6: Requests that arrive back to back produce rsp_valid high on every cycle from the first word of the first burst to the last word of the final burst. This holds for every latency, including when the device bursts longer than four.
- R7: Every presented word carries rsp_tag equal to its request's tag and rsp_idx equal to k. rsp_last is high only on k = 3.
- R8: Words the device returns beyond the fourth word of a burst, when it is programmed for a longer burst, never raise rsp_valid.
- R9: sd_dqm is 0 in the cycle a READ is on the bus and in every cycle that precedes a capture edge. It returns to 1 once no read is outstanding.
- R10: cfg_cas_lat is taken only while no read is outstanding. A change made while a read is in flight does not alter the latency of reads already issued or issued back to back after it. The change takes effect after the stream drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_cas_lat | input | CL_W (2) | Requested CAS latency, 0 treated as 1 |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request can be issued this cycle |
| req_bank | input | BANK_W (2) | Bank of the request |
| req_col | input | COL_W (8) | Starting column of the request |
| req_tag | input | TAG_W (4) | Tag returned with the request's data |
| sd_cmd | output | 3 | ras_n, cas_n, we_n levels: 3'b101 READ, 3'b111 NOP |
| sd_ba | output | BANK_W (2) | Bank address lines |
| sd_addr | output | COL_W (8) | Column address lines |
| sd_dqm | output | 1 | Data mask, low while reads are outstanding |
| sd_dq_in | input | DATA_W (16) | Data returned by the device |
| rsp_valid | output | 1 | A captured word is presented |
| rsp_data | output | DATA_W (16) | Captured word |
| rsp_tag | output | TAG_W (4) | Tag of the request the word belongs to |
| rsp_idx | output | IDX_W (2) | Word index within the burst |
| rsp_last | output | 1 | Fourth word of the burst |

## Verification
A wrong word counter or latency tap shows up within one burst. rsp_valid rises a cycle early or late, or a tag lands on a neighbour's word, and this is visible at the first capture after the READ. A fault in the acceptance cadence shows up within one request period. Either a READ comes fewer than four cycles after the previous one, or a gap opens in the response stream. A latency taken while reads are in flight moves the first word of the next burst, and this shows on the very next response cycle.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  // Command encodings on {ras_n, cas_n, we_n}
  localparam logic [2:0] SD_CMD_READ = 3'b101;
  localparam logic [2:0] SD_CMD_NOP  = 3'b111;

endpackage

// File: rtl/sdr_rd_issue.sv
module sdr_rd_issue
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 8,
  parameter int TAG_W     = 4,
  parameter int BURST_LEN = 4,
  parameter int IDX_W     = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              fire,
  output logic              gen_v,
  output logic [IDX_W-1:0]  gen_idx,
  output logic [TAG_W-1:0]  gen_tag,
  output logic [2:0]        sd_cmd,
  output logic [BANK_W-1:0] sd_ba,
  output logic [COL_W-1:0]  sd_addr
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BURST_LEN - 1);

  // burst word generator: one entry per word, advances every cycle
  logic             gen_v_q,   gen_v_d;
  logic [IDX_W-1:0] gen_idx_q, gen_idx_d;
  logic [TAG_W-1:0] gen_tag_q;
  logic             gen_tag_en;

  logic [2:0]        cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q;
  logic [COL_W-1:0]  addr_q;
  logic              addr_en;

  // next-state logic
  always_comb begin
    // a new READ is legal when no word is pending or the final word leaves now
    req_ready  = !gen_v_q || (gen_idx_q == IDX_LAST);
    fire       = req_valid && req_ready;

    gen_v_d    = gen_v_q;
    gen_idx_d  = gen_idx_q;
    gen_tag_en = 1'b0;
    if (fire) begin
      gen_v_d    = 1'b1;
      gen_idx_d  = '0;
      gen_tag_en = 1'b1;
    end else if (gen_v_q) begin
      if (gen_idx_q == IDX_LAST) begin
        gen_v_d   = 1'b0;
        gen_idx_d = '0;
      end else begin
        gen_idx_d = gen_idx_q + IDX_W'(1);
      end
    end

    cmd_d   = fire ? SD_CMD_READ : SD_CMD_NOP;
    addr_en = fire;
  end

  // registers with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_v_q   <= 1'b0;
      gen_idx_q <= '0;
      cmd_q     <= SD_CMD_NOP;
    end else begin
      gen_v_q   <= gen_v_d;
      gen_idx_q <= gen_idx_d;
      cmd_q     <= cmd_d;
    end
  end

  // data registers, enable only
  always_ff @(posedge clk) begin
    if (gen_tag_en) gen_tag_q <= req_tag;
    if (addr_en) begin
      ba_q   <= req_bank;
      addr_q <= req_col;
    end
  end

  assign gen_v   = gen_v_q;
  assign gen_idx = gen_idx_q;
  assign gen_tag = gen_tag_q;
  assign sd_cmd  = cmd_q;
  assign sd_ba   = ba_q;
  assign sd_addr = addr_q;

  // R3: while the READ is on the bus, no further request may be taken
  assert_ready_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == SD_CMD_READ) |-> !req_ready);

  // R2: a READ occupies the bus for a single cycle
  assert_read_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == SD_CMD_READ) |=> (cmd_q == SD_CMD_NOP));

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 4,
  parameter int BURST_LEN = 4,
  parameter int MAX_CL    = 3,
  parameter int IDX_W     = $clog2(BURST_LEN),
  parameter int CL_W      = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CL_W-1:0]   cfg_cas_lat,
  input  logic              fire,
  input  logic              in_v,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic              rsp_last,
  output logic              dqm
);

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BURST_LEN - 1);

  // word-tag shift register, one stage per cycle of latency
  logic [MAX_CL-1:0] st_v, st_v_d;
  logic [IDX_W-1:0]  st_idx   [MAX_CL];
  logic [IDX_W-1:0]  st_idx_d [MAX_CL];
  logic [TAG_W-1:0]  st_tag   [MAX_CL];
  logic [TAG_W-1:0]  st_tag_d [MAX_CL];

  logic [CL_W-1:0] cl_q, cl_d, cfg_cl;
  logic [CL_W-1:0] tap;
  logic            busy;
  logic            cap_v;
  logic            dqm_q, dqm_d;

  logic              rsp_v_q, rsp_v_d;
  logic              rsp_last_q, rsp_last_d;
  logic [DATA_W-1:0] rsp_data_q;
  logic [TAG_W-1:0]  rsp_tag_q;
  logic [IDX_W-1:0]  rsp_idx_q;

  always_comb begin
    st_v_d[0]   = in_v;
    st_idx_d[0] = in_idx;
    st_tag_d[0] = in_tag;
    for (int i = 1; i < MAX_CL; i++) begin
      st_v_d[i]   = st_v[i-1];
      st_idx_d[i] = st_idx[i-1];
      st_tag_d[i] = st_tag[i-1];
    end
  end

  generate
    for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_v[g] <= 1'b0;
        else        st_v[g] <= st_v_d[g];
      end
      always_ff @(posedge clk) begin
        if (st_v_d[g]) begin
          st_idx[g] <= st_idx_d[g];
          st_tag[g] <= st_tag_d[g];
        end
      end
    end
  endgenerate

  // latency selection: taken only when nothing is outstanding
  always_comb begin
    if (cfg_cas_lat == '0)                 cfg_cl = CL_W'(1);
    else if (int'(cfg_cas_lat) > MAX_CL)   cfg_cl = CL_W'(MAX_CL);
    else                                   cfg_cl = cfg_cas_lat;

    busy  = fire || in_v || (|st_v);
    cl_d  = busy ? cl_q : cfg_cl;
    dqm_d = !busy;

    tap   = cl_q - CL_W'(1);
    cap_v = st_v[tap];

    rsp_v_d    = cap_v;
    rsp_last_d = cap_v && (st_idx[tap] == IDX_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q       <= CL_W'(MAX_CL);
      dqm_q      <= 1'b1;
      rsp_v_q    <= 1'b0;
      rsp_last_q <= 1'b0;
    end else begin
      cl_q       <= cl_d;
      dqm_q      <= dqm_d;
      rsp_v_q    <= rsp_v_d;
      rsp_last_q <= rsp_last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_v) begin
      rsp_data_q <= dq_in;
      rsp_tag_q  <= st_tag[tap];
      rsp_idx_q  <= st_idx[tap];
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_tag   = rsp_tag_q;
  assign rsp_idx   = rsp_idx_q;
  assign rsp_last  = rsp_last_q;
  assign dqm       = dqm_q;

  // R9: mask is low whenever a word is about to be sampled
  assert_dqm_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_v |-> !dqm_q);

  // R10: latency cannot move while words are in the shift register
  assert_cl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|st_v) |-> $stable(cl_q));

  // R7: word indices enter the pipeline in order
  assert_idx_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v[0] && (st_idx[0] != '0)) |->
      ($past(st_v[0]) && (st_idx[0] == $past(st_idx[0]) + IDX_W'(1))));

  // R3: a new burst enters only after the previous one's final word
  assert_burst_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_v[0] && (st_idx[0] == '0)) |->
      (!$past(st_v[0]) || ($past(st_idx[0]) == IDX_LAST)));

endmodule

// File: rtl/sdr_rd_sched.sv
module sdr_rd_sched
  import sdr_rd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 4,
  parameter int BURST_LEN = 4,
  parameter int MAX_CL    = 3,
  parameter int IDX_W     = $clog2(BURST_LEN),
  parameter int CL_W      = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CL_W-1:0]   cfg_cas_lat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [TAG_W-1:0]  req_tag,
  output logic [2:0]        sd_cmd,
  output logic [BANK_W-1:0] sd_ba,
  output logic [COL_W-1:0]  sd_addr,
  output logic              sd_dqm,
  input  logic [DATA_W-1:0] sd_dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic              rsp_last
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             fire;
  logic             gen_v;
  logic [IDX_W-1:0] gen_idx;
  logic [TAG_W-1:0] gen_tag;

  sdr_rd_issue #(
    .BANK_W(BANK_W), .COL_W(COL_W), .TAG_W(TAG_W),
    .BURST_LEN(BURST_LEN), .IDX_W(IDX_W)
  ) u_issue (
    .clk(clk), .rst_n(rst_sync_q),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_tag(req_tag),
    .fire(fire), .gen_v(gen_v), .gen_idx(gen_idx), .gen_tag(gen_tag),
    .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr)
  );

  sdr_rd_pipe #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .BURST_LEN(BURST_LEN),
    .MAX_CL(MAX_CL), .IDX_W(IDX_W), .CL_W(CL_W)
  ) u_pipe (
    .clk(clk), .rst_n(rst_sync_q), .cfg_cas_lat(cfg_cas_lat),
    .fire(fire), .in_v(gen_v), .in_idx(gen_idx), .in_tag(gen_tag),
    .dq_in(sd_dq_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .rsp_idx(rsp_idx), .rsp_last(rsp_last), .dqm(sd_dqm)
  );

  // R9: the mask is already low while a READ is on the bus
  assert_cmd_dqm_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (sd_cmd == SD_CMD_READ) |-> !sd_dqm);

  // R7: the last flag is only ever raised on a presented word
  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rsp_last |-> rsp_valid);

endmodule

// File: tb/sdr_rd_sched_tb.sv
module sdr_rd_sched_tb;

  localparam int BL   = 4;
  localparam int EMAX = 4096;
  localparam logic [2:0] RD = 3'b101;
  localparam logic [2:0] NP = 3'b111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_cas_lat;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_bank;
  logic [7:0]  req_col;
  logic [3:0]  req_tag;
  logic [2:0]  sd_cmd;
  logic [1:0]  sd_ba;
  logic [7:0]  sd_addr;
  logic        sd_dqm;
  logic [15:0] sd_dq_in;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [3:0]  rsp_tag;
  logic [1:0]  rsp_idx;
  logic        rsp_last;

  sdr_rd_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_tag(req_tag),
    .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_dq_in(sd_dq_in),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .rsp_idx(rsp_idx), .rsp_last(rsp_last)
  );

  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int fails  = 0;
  int ecnt   = 0;          // rising edges seen so far
  always @(posedge clk) ecnt <= ecnt + 1;

  int    cl_eff  = 3;
  int    mlen    = 4;      // words the device model returns per READ
  bit    sim_on  = 1'b0;
  string phase   = "R4";
  int    run_len = 0;
  int    max_run = 0;
  int    last_rd = -100;

  bit          exp_v [EMAX];
  logic [15:0] exp_d [EMAX];
  logic [3:0]  exp_t [EMAX];
  int          exp_i [EMAX];

  int         fq_e [256];
  logic [1:0] fq_b [256];
  logic [7:0] fq_c [256];
  logic [3:0] fq_t [256];
  int         fq_wr = 0;
  int         fq_rd = 0;

  int         rs_e  [2];
  int         rs_cl [2];
  logic [1:0] rs_b  [2];
  logic [7:0] rs_c  [2];
  bit         rs_ok [2];
  int         rs_new = 0;

  function automatic logic [15:0] word_of(input logic [1:0] b, input logic [7:0] c);
    return {2'b10, b, 4'h0, c};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", req, what, act, expv, ecnt);
    end
  endtask

  // monitor and device model, all at the falling edge
  always @(negedge clk) begin
    if (sim_on) begin
      // response for the capture edge just passed
      if (ecnt < EMAX) begin
        chk(rsp_valid === exp_v[ecnt], {"R4 R8 ", phase}, "rsp_valid",
            32'(rsp_valid), 32'(exp_v[ecnt]));
        if (exp_v[ecnt] && rsp_valid === 1'b1) begin
          chk(rsp_data === exp_d[ecnt], {"R4 ", phase}, "rsp_data", 32'(rsp_data), 32'(exp_d[ecnt]));
          chk(rsp_tag === exp_t[ecnt], "R7", "rsp_tag", 32'(rsp_tag), 32'(exp_t[ecnt]));
          chk(int'(rsp_idx) == exp_i[ecnt], "R7", "rsp_idx", 32'(rsp_idx), 32'(exp_i[ecnt]));
          chk(rsp_last === (exp_i[ecnt] == BL - 1), "R7", "rsp_last",
              32'(rsp_last), 32'(exp_i[ecnt] == BL - 1));
        end
      end
      if (rsp_valid === 1'b1) run_len++;
      else run_len = 0;
      if (run_len > max_run) max_run = run_len;

      if (ecnt + 1 < EMAX && exp_v[ecnt + 1])
        chk(sd_dqm === 1'b0, "R9", "dqm before capture", 32'(sd_dqm), 0);

      // command bus
      if (sd_cmd === RD) begin
        chk(fq_rd != fq_wr, "R2", "READ without request", 1, 0);
        if (fq_rd != fq_wr) begin
          chk(fq_e[fq_rd % 256] == ecnt, "R2", "READ cycle", 32'(ecnt), 32'(fq_e[fq_rd % 256]));
          chk(sd_ba === fq_b[fq_rd % 256], "R2", "sd_ba", 32'(sd_ba), 32'(fq_b[fq_rd % 256]));
          chk(sd_addr === fq_c[fq_rd % 256], "R2", "sd_addr", 32'(sd_addr), 32'(fq_c[fq_rd % 256]));
          chk(sd_dqm === 1'b0, "R9", "dqm with READ", 32'(sd_dqm), 0);
          chk(ecnt - last_rd >= BL, "R3", "READ spacing", 32'(ecnt - last_rd), BL);
          last_rd = ecnt;
          for (int k = 0; k < BL; k++) begin
            int e;
            e = ecnt + 1 + cl_eff + k;
            if (e < EMAX) begin
              exp_v[e] = 1'b1;
              exp_d[e] = word_of(fq_b[fq_rd % 256], fq_c[fq_rd % 256] + 8'(k));
              exp_t[e] = fq_t[fq_rd % 256];
              exp_i[e] = k;
            end
          end
          rs_new         = rs_new ^ 1;
          rs_e[rs_new]   = ecnt + 1;
          rs_cl[rs_new]  = cl_eff;
          rs_b[rs_new]   = fq_b[fq_rd % 256];
          rs_c[rs_new]   = fq_c[fq_rd % 256];
          rs_ok[rs_new]  = 1'b1;
          fq_rd++;
        end
      end else begin
        chk(sd_cmd === NP, "R2", "idle command", 32'(sd_cmd), 32'(NP));
      end
    end

    // device output for the next edge: newest READ that has data due wins
    begin
      bit found;
      found    = 1'b0;
      sd_dq_in = 16'hDEAD;
      for (int s = 0; s < 2; s++) begin
        int j, k;
        j = (s == 0) ? rs_new : (rs_new ^ 1);
        k = ecnt + 1 - rs_e[j] - rs_cl[j];
        if (!found && rs_ok[j] && k >= 0 && k < mlen) begin
          sd_dq_in = word_of(rs_b[j], rs_c[j] + 8'(k));
          found    = 1'b1;
        end
      end
    end
  end

  // called at a falling edge; returns at the falling edge after the handshake
  task automatic send(input logic [1:0] b, input logic [7:0] c, input logic [3:0] t);
    req_valid = 1'b1;
    req_bank  = b;
    req_col   = c;
    req_tag   = t;
    #1;
    while (req_ready !== 1'b1) begin
      @(negedge clk);
      #1;
    end
    fq_e[fq_wr % 256] = ecnt + 1;
    fq_b[fq_wr % 256] = b;
    fq_c[fq_wr % 256] = c;
    fq_t[fq_wr % 256] = t;
    fq_wr++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #3000000;
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    req_valid   = 1'b0;
    req_bank    = '0;
    req_col     = '0;
    req_tag     = '0;
    cfg_cas_lat = 2'd3;
    sd_dq_in    = '0;
    for (int i = 0; i < 2; i++) begin
      rs_ok[i] = 1'b0; rs_e[i] = 0; rs_cl[i] = 1; rs_b[i] = '0; rs_c[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(sd_cmd === NP, "R1", "reset cmd", 32'(sd_cmd), 32'(NP));
    chk(sd_dqm === 1'b1, "R1", "reset dqm", 32'(sd_dqm), 1);
    chk(rsp_valid === 1'b0, "R1", "reset rsp_valid", 32'(rsp_valid), 0);
    chk(req_ready === 1'b1, "R1", "reset ready", 32'(req_ready), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    sim_on = 1'b1;

    for (int cv = 0; cv < 4; cv++) begin
      cfg_cas_lat = 2'(cv);
      repeat (3) @(negedge clk);
      cl_eff = (cv == 0) ? 1 : cv;

      // single request, latency sweep (R5)
      phase = "R5";
      send(2'(cv), 8'h10 + 8'(cv), 4'(cv));
      repeat (12) @(negedge clk);

      // stream with repeated and changing banks (R3, R6)
      phase   = "R6";
      max_run = 0;
      for (int i = 0; i < 6; i++) begin
        logic [1:0] bk;
        bk = (i < 2) ? 2'd1 : ((i < 4) ? 2'd2 : 2'(i));
        send(bk, 8'h40 + 8'(i * 8), 4'(i + 4));
      end
      repeat (12) @(negedge clk);
      chk(max_run == 6 * BL, "R6", "gapless run length", 32'(max_run), 6 * BL);

      // ready pattern after one handshake (R3)
      phase = "R3";
      send(2'd3, 8'hF0, 4'hA);
      chk(req_ready === 1'b0, "R3", "ready after handshake +0", 32'(req_ready), 0);
      @(negedge clk);
      chk(req_ready === 1'b0, "R3", "ready after handshake +1", 32'(req_ready), 0);
      @(negedge clk);
      chk(req_ready === 1'b0, "R3", "ready after handshake +2", 32'(req_ready), 0);
      @(negedge clk);
      chk(req_ready === 1'b1, "R3", "ready after handshake +3", 32'(req_ready), 1);
      repeat (10) @(negedge clk);

      // device bursts of eight: extra words ignored, next READ truncates (R8)
      phase = "R8";
      mlen  = 8;
      send(2'd0, 8'hFC, 4'hB);
      repeat (16) @(negedge clk);
      max_run = 0;
      send(2'd2, 8'h20, 4'hC);
      send(2'd2, 8'h80, 4'hD);
      send(2'd1, 8'h33, 4'hE);
      repeat (16) @(negedge clk);
      chk(max_run == 3 * BL, "R6", "truncated stream run length", 32'(max_run), 3 * BL);
      mlen = 4;
      chk(sd_dqm === 1'b1, "R9", "dqm idle", 32'(sd_dqm), 1);
    end

    // latency change while reads are in flight (R10)
    cfg_cas_lat = 2'd3;
    repeat (3) @(negedge clk);
    cl_eff = 3;
    phase  = "R10";
    send(2'd0, 8'h01, 4'h1);
    cfg_cas_lat = 2'd1;
    send(2'd1, 8'h11, 4'h2);
    send(2'd2, 8'h21, 4'h3);
    repeat (14) @(negedge clk);
    cl_eff = 1;
    send(2'd3, 8'h31, 4'h4);
    repeat (10) @(negedge clk);
    chk(sd_dqm === 1'b1, "R9", "dqm idle at end", 32'(sd_dqm), 1);

    summary();
    $finish;
  end

endmodule